// File: doc/BRIEF.md
# Clock divider reconfiguration sequencer

This block produces one divided clock enable per output channel and changes the divide setting of any channel without producing a short or glitched period. Each channel holds an 8-bit divide field, a bypass bit and an external-source select bit. When bypass is clear, the channel emits a one-cycle enable pulse every N cycles of the source clock. When bypass is set, the channel passes through a crystal-reference enable pulse instead.

A request names a channel and a new integer divider. A channel is built in one of two styles, chosen per channel by a parameter mask. A PLL-fed channel is moved onto the crystal reference while its divider is rewritten. The block first points the bypass path at the crystal, then sets bypass, writes the field, holds for a settle time given in picoseconds, and then releases bypass. A plain divider channel has its bypass cleared and its field written on the next cycle. Requests are accepted one at a time through a valid/ready pair, and each one finishes with a one-cycle completion pulse that carries a success flag.

Top module: `clkreseq_top`

## Requirements
- R1: After reset, PLL-style channels have bypass 0 and source select 1, plain channels have bypass 1 and source select 0, every divide field equals the reset divider (4 by default), and `req_ready` is 1.
- R2: While a channel's bypass is 0, `ch_tick` for that channel is a one-cycle pulse every N source cycles. N is the divide field, except that a field of 0 means N = 256.
- R3: A request value from 1 to 255 is written into the field unchanged. Any value of 256 or more is written as field 0, which is divide-by-256.
- R4: A request value of 0, or a channel index beyond the last channel, changes no bypass, select or field bit and completes with `done_ok` = 0.
- R5: While a channel's bypass is 1, its `ch_tick` equals `xtal_tick`.
- R6: For a PLL-style channel, the source select is cleared first, bypass is set on a later cycle, and the field is written on a cycle after that.
- R7: For a PLL-style channel, bypass stays 1 for at least the settle cycle count (settle time divided by clock period, rounded up) after the field write, and it is 0 again when `done` pulses.
- R8: For a plain channel, bypass is cleared before the field is written, and the source select is never changed.
- R9: A new divide field takes effect only at the channel's next terminal count, so the period in progress finishes with the old divisor.
- R10: `req_ready` is 0 from the cycle after acceptance until `done`, `done` lasts one cycle, and `req_ready` is 1 on the cycle after `done`.
- R11: An accepted request with a nonzero value on a valid channel completes with `done_ok` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock, which is also the clock being divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_tick | input | 1 | Crystal-reference enable pulse, passed through while a channel is bypassed |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_ch | input | CH_W | Target channel index |
| req_div | input | REQ_W | Requested integer divider |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Request succeeded; valid while `done` is 1 |
| ch_tick | output | NCH | Per-channel divided enable |
| ch_bypass | output | NCH | Per-channel bypass bit |
| ch_ext_sel | output | NCH | Per-channel external-source select bit |
| ch_div_field | output | 8*NCH | Per-channel divide fields; channel i occupies bits [8i+7:8i] |

## Verification
The bench builds two channels. Channel 0 is PLL-style and channel 1 is plain, with a 20 ns clock and a 200 ns settle time, which gives a settle count of 10 cycles. Because the field is only 8 bits wide, the plain channel is swept through every request value from 1 to 256 and the divided period is measured each time. Saturating values above that range are also applied, and the PLL channel is swept over small dividers and divide-by-256 while the order of its select, bypass and write steps is timed. Mid-period changes, zero requests and bypass pass-through are each exercised on both channel styles.

// File: rtl/clkreseq_pkg.sv
package clkreseq_pkg;

    localparam int unsigned FIELD_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SRC,
        ST_BYP_ON,
        ST_WRITE_P,
        ST_SETTLE,
        ST_RELEASE,
        ST_UNBYP,
        ST_WRITE_S,
        ST_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CLR_EXT,
        OP_SET_BYP,
        OP_CLR_BYP,
        OP_WR_DIV
    } chan_op_e;

    // Saturating encoding: 1..255 kept, 256 and above become 0 (divide-by-256)
    function automatic logic [FIELD_W-1:0] encode_div(input logic [31:0] value);
        return (value >= 32'd256) ? '0 : value[FIELD_W-1:0];
    endfunction

endpackage

// File: rtl/clkreseq_tickgen.sv
module clkreseq_tickgen
    import clkreseq_pkg::*;
#(
    parameter logic [FIELD_W-1:0] RST_FIELD = 8'd4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] field,
    output logic               pulse
);

    typedef struct packed {
        logic [FIELD_W-1:0] cnt;
        logic [FIELD_W-1:0] act;
    } tg_state_t;

    tg_state_t q, d;
    logic      term;

    // 8-bit wrap makes field 0 terminate at 255, i.e. divide-by-256
    assign term  = (q.cnt == (q.act - 8'd1));
    assign pulse = term;

    always_comb begin
        d = q;
        if (term) begin
            d.cnt = '0;
            d.act = field;
        end else begin
            d.cnt = q.cnt + 8'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{cnt: '0, act: RST_FIELD};
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/clkreseq_chan.sv
module clkreseq_chan
    import clkreseq_pkg::*;
#(
    parameter int unsigned        CH_W      = 1,
    parameter int unsigned        IDX       = 0,
    parameter bit                 IS_PLL    = 1'b1,
    parameter logic [FIELD_W-1:0] RST_FIELD = 8'd4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xtal_tick,
    input  chan_op_e           op,
    input  logic [CH_W-1:0]    op_ch,
    input  logic [FIELD_W-1:0] op_field,
    output logic               tick,
    output logic               bypass,
    output logic               ext_sel,
    output logic [FIELD_W-1:0] div_field
);

    typedef struct packed {
        logic               byp;
        logic               ext;
        logic [FIELD_W-1:0] field;
    } ch_state_t;

    ch_state_t q, d;
    logic      hit;
    logic      div_pulse;

    assign hit = (op_ch == CH_W'(IDX));

    always_comb begin
        d = q;
        if (hit) begin
            case (op)
                OP_CLR_EXT: d.ext   = 1'b0;
                OP_SET_BYP: d.byp   = 1'b1;
                OP_CLR_BYP: d.byp   = 1'b0;
                OP_WR_DIV:  d.field = op_field;
                default:    d       = q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{byp: !IS_PLL, ext: IS_PLL, field: RST_FIELD};
        end else begin
            q <= d;
        end
    end

    clkreseq_tickgen #(
        .RST_FIELD (RST_FIELD)
    ) u_tickgen (
        .clk   (clk),
        .rst_n (rst_n),
        .field (q.field),
        .pulse (div_pulse)
    );

    assign tick      = q.byp ? xtal_tick : div_pulse;
    assign bypass    = q.byp;
    assign ext_sel   = q.ext;
    assign div_field = q.field;

endmodule

// File: rtl/clkreseq_ctrl.sv
module clkreseq_ctrl
    import clkreseq_pkg::*;
#(
    parameter int unsigned     NCH        = 2,
    parameter int unsigned     CH_W       = 1,
    parameter int unsigned     REQ_W      = 16,
    parameter logic [NCH-1:0]  PLL_MASK   = NCH'(1),
    parameter int unsigned     SETTLE_CYC = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [CH_W-1:0]    req_ch,
    input  logic [REQ_W-1:0]   req_div,
    output logic               req_ready,
    output chan_op_e           op,
    output logic [CH_W-1:0]    op_ch,
    output logic [FIELD_W-1:0] op_field,
    output logic               done,
    output logic               done_ok
);

    localparam int unsigned WCNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC + 1) : 1;

    typedef struct packed {
        seq_state_e         st;
        logic [CH_W-1:0]    ch;
        logic [FIELD_W-1:0] field;
        logic               ok;
        logic [WCNT_W-1:0]  wcnt;
    } seq_t;

    seq_t               q, d;
    logic               ch_known;
    logic               ch_is_pll;
    logic               req_nonzero;
    logic [FIELD_W-1:0] div_enc;

    always_comb begin
        ch_known  = 1'b0;
        ch_is_pll = 1'b0;
        for (int i = 0; i < int'(NCH); i++) begin
            if (req_ch == CH_W'(i)) begin
                ch_known  = 1'b1;
                ch_is_pll = PLL_MASK[i];
            end
        end
    end

    assign req_nonzero = (req_div != '0);
    assign div_enc     = encode_div(32'(req_div));

    always_comb begin
        d  = q;
        op = OP_NONE;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.ch    = req_ch;
                    d.field = div_enc;
                    d.wcnt  = '0;
                    if (!req_nonzero || !ch_known) begin
                        d.ok = 1'b0;
                        d.st = ST_DONE;
                    end else begin
                        d.ok = 1'b1;
                        d.st = ch_is_pll ? ST_SRC : ST_UNBYP;
                    end
                end
            end
            ST_SRC: begin
                op   = OP_CLR_EXT;
                d.st = ST_BYP_ON;
            end
            ST_BYP_ON: begin
                op   = OP_SET_BYP;
                d.st = ST_WRITE_P;
            end
            ST_WRITE_P: begin
                op     = OP_WR_DIV;
                d.wcnt = '0;
                d.st   = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (q.wcnt == WCNT_W'(SETTLE_CYC - 1)) begin
                    d.st = ST_RELEASE;
                end else begin
                    d.wcnt = q.wcnt + 1'b1;
                end
            end
            ST_RELEASE: begin
                op   = OP_CLR_BYP;
                d.st = ST_DONE;
            end
            ST_UNBYP: begin
                op   = OP_CLR_BYP;
                d.st = ST_WRITE_S;
            end
            ST_WRITE_S: begin
                op   = OP_WR_DIV;
                d.st = ST_DONE;
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ch: '0, field: '0, ok: 1'b0, wcnt: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign done      = (q.st == ST_DONE);
    assign done_ok   = q.ok;
    assign op_ch     = q.ch;
    assign op_field  = q.field;

endmodule

// File: rtl/clkreseq_top.sv
module clkreseq_top
    import clkreseq_pkg::*;
#(
    parameter int unsigned    NCH           = 2,
    parameter logic [NCH-1:0] PLL_MASK      = NCH'(1),
    parameter int unsigned    REQ_W         = 16,
    parameter int unsigned    DIV_RST       = 4,
    parameter int unsigned    CLK_PERIOD_PS = 20000,
    parameter int unsigned    SETTLE_PS     = 200000,
    localparam int unsigned   CH_W          = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xtal_tick,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [CH_W-1:0]      req_ch,
    input  logic [REQ_W-1:0]     req_div,
    output logic                 done,
    output logic                 done_ok,
    output logic [NCH-1:0]       ch_tick,
    output logic [NCH-1:0]       ch_bypass,
    output logic [NCH-1:0]       ch_ext_sel,
    output logic [NCH*FIELD_W-1:0] ch_div_field
);

    localparam int unsigned SETTLE_RAW = (SETTLE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int unsigned SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
    localparam logic [FIELD_W-1:0] RST_FIELD = (DIV_RST >= 256) ? 8'd0 : FIELD_W'(DIV_RST);

    chan_op_e           op;
    logic [CH_W-1:0]    op_ch;
    logic [FIELD_W-1:0] op_field;

    clkreseq_ctrl #(
        .NCH        (NCH),
        .CH_W       (CH_W),
        .REQ_W      (REQ_W),
        .PLL_MASK   (PLL_MASK),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ch    (req_ch),
        .req_div   (req_div),
        .req_ready (req_ready),
        .op        (op),
        .op_ch     (op_ch),
        .op_field  (op_field),
        .done      (done),
        .done_ok   (done_ok)
    );

    for (genvar g = 0; g < int'(NCH); g++) begin : g_ch
        clkreseq_chan #(
            .CH_W      (CH_W),
            .IDX       (g),
            .IS_PLL    (PLL_MASK[g]),
            .RST_FIELD (RST_FIELD)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .xtal_tick (xtal_tick),
            .op        (op),
            .op_ch     (op_ch),
            .op_field  (op_field),
            .tick      (ch_tick[g]),
            .bypass    (ch_bypass[g]),
            .ext_sel   (ch_ext_sel[g]),
            .div_field (ch_div_field[g*FIELD_W +: FIELD_W])
        );
    end

endmodule

// File: rtl/clkreseq_chk.sv
module clkreseq_chk #(
    parameter int unsigned    NCH           = 2,
    parameter logic [NCH-1:0] PLL_MASK      = NCH'(1),
    parameter int unsigned    CLK_PERIOD_PS = 20000,
    parameter int unsigned    SETTLE_PS     = 200000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xtal_tick,
    input logic             req_ready,
    input logic             done,
    input logic             done_ok,
    input logic [NCH-1:0]   ch_tick,
    input logic [NCH-1:0]   ch_bypass,
    input logic [NCH-1:0]   ch_ext_sel,
    input logic [NCH*8-1:0] ch_div_field
);

    localparam int unsigned SETTLE_RAW = (SETTLE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int unsigned SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;

    assert_done_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_ready_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    assert_fail_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_ok) |-> ($stable(ch_div_field) && $stable(ch_bypass) && $stable(ch_ext_sel)));

    for (genvar g = 0; g < int'(NCH); g++) begin : g_chk
        assert_bypass_xtal_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ch_bypass[g] |-> (ch_tick[g] == xtal_tick));

        if (PLL_MASK[g]) begin : g_pll
            logic [15:0] byp_run_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    byp_run_q <= '0;
                end else if (!ch_bypass[g]) begin
                    byp_run_q <= '0;
                end else if (byp_run_q != 16'hFFFF) begin
                    byp_run_q <= byp_run_q + 16'd1;
                end
            end

            assert_select_before_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ch_bypass[g]) |-> !ch_ext_sel[g]);

            assert_write_only_bypassed_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !ch_bypass[g] |=> $stable(ch_div_field[g*8 +: 8]));

            assert_settle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ch_bypass[g]) |-> (32'(byp_run_q) >= SETTLE_CYC + 1));
        end else begin : g_plain
            assert_select_untouched_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !ch_ext_sel[g]);

            assert_write_unbypassed_R8: assert property (@(posedge clk) disable iff (!rst_n)
                ch_bypass[g] |=> ($stable(ch_div_field[g*8 +: 8]) || !ch_bypass[g]));
        end
    end

endmodule

bind clkreseq_top clkreseq_chk #(
    .NCH           (NCH),
    .PLL_MASK      (PLL_MASK),
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .SETTLE_PS     (SETTLE_PS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .xtal_tick    (xtal_tick),
    .req_ready    (req_ready),
    .done         (done),
    .done_ok      (done_ok),
    .ch_tick      (ch_tick),
    .ch_bypass    (ch_bypass),
    .ch_ext_sel   (ch_ext_sel),
    .ch_div_field (ch_div_field)
);

// File: tb/tb_clkreseq_top.sv
module tb_clkreseq_top;

    localparam int NCH    = 2;
    localparam int SETTLE = (200000 + 20000 - 1) / 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_tick = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [0:0]  req_ch = '0;
    logic [15:0] req_div = '0;
    logic        done;
    logic        done_ok;
    logic [1:0]  ch_tick;
    logic [1:0]  ch_bypass;
    logic [1:0]  ch_ext_sel;
    logic [15:0] ch_div_field;

    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    clkreseq_top #(
        .NCH           (NCH),
        .PLL_MASK      (2'b01),
        .REQ_W         (16),
        .DIV_RST       (4),
        .CLK_PERIOD_PS (20000),
        .SETTLE_PS     (200000)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .xtal_tick    (xtal_tick),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_ch       (req_ch),
        .req_div      (req_div),
        .done         (done),
        .done_ok      (done_ok),
        .ch_tick      (ch_tick),
        .ch_bypass    (ch_bypass),
        .ch_ext_sel   (ch_ext_sel),
        .ch_div_field (ch_div_field)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            @(posedge clk);
            xtal_tick <= ((cyc % 5) == 0);
        end
    end

    function automatic int fld(input int ch);
        return int'(ch_div_field[ch*8 +: 8]);
    endfunction

    function automatic int period_of(input int f);
        return (f == 0) ? 256 : f;
    endfunction

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Waits for the next tick on a channel (starting at the next negedge)
    task automatic next_tick(input int ch, output int stamp);
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!ch_tick[ch] && guard < 700);
        stamp = cyc;
        if (guard >= 700) chk(1'b0, "R2 tick timeout", guard, 700);
    endtask

    task automatic measure(input int ch, output int iv);
        int t1, t2;
        next_tick(ch, t1);
        next_tick(ch, t2);
        iv = t2 - t1;
    endtask

    // Called at a negedge with the sequencer idle
    task automatic do_req(input int ch, input int unsigned val, output bit ok);
        bit b0, e0, pb, pe;
        int f0, pf, expf;
        int t_ext = -1, t_on = -1, t_wr = -1, t_off = -1;
        int guard = 0;
        b0 = ch_bypass[ch]; e0 = ch_ext_sel[ch]; f0 = fld(ch);
        pb = b0; pe = e0; pf = f0;
        expf = (val == 0) ? f0 : ((val >= 256) ? 0 : int'(val));
        req_valid = 1'b1;
        req_ch    = 1'(ch);
        req_div   = 16'(val);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (!done) chk(req_ready == 1'b0, "R10 busy ready", int'(req_ready), 0);
        while (1) begin
            if (ch_bypass[ch] !== pb) begin
                if (ch_bypass[ch]) t_on = cyc; else t_off = cyc;
                pb = ch_bypass[ch];
            end
            if (ch_ext_sel[ch] !== pe) begin
                if (!ch_ext_sel[ch]) t_ext = cyc;
                pe = ch_ext_sel[ch];
            end
            if (fld(ch) != pf) begin
                t_wr = cyc;
                pf = fld(ch);
            end
            if (ch_bypass[ch]) chk(ch_tick[ch] == xtal_tick, "R5 bypass passthrough", int'(ch_tick[ch]), int'(xtal_tick));
            if (done) break;
            guard++;
            if (guard > 100) begin
                chk(1'b0, "R10 no done", guard, 100);
                break;
            end
            @(negedge clk);
        end
        ok = done_ok;
        @(negedge clk);
        chk(req_ready && !done, "R10 ready after done", int'(req_ready), 1);
        if (val == 0) begin
            chk(!ok, "R4 zero request status", int'(ok), 0);
            chk(fld(ch) == f0, "R4 zero request field", fld(ch), f0);
            chk(t_on == -1 && t_off == -1 && t_ext == -1, "R4 zero request bits", t_on, -1);
        end else begin
            chk(ok, "R11 success status", int'(ok), 1);
            chk(fld(ch) == expf, "R3 field encoding", fld(ch), expf);
            if (ch == 0) begin
                chk(!ch_bypass[0], "R7 released", int'(ch_bypass[0]), 0);
                chk(!ch_ext_sel[0], "R6 select cleared", int'(ch_ext_sel[0]), 0);
                if (expf != f0) begin
                    if (e0) chk(t_ext >= 0 && t_on > t_ext, "R6 select before bypass", t_on, t_ext + 1);
                    chk(t_on >= 0 && t_wr > t_on, "R6 write after bypass", t_wr, t_on + 1);
                    chk(t_off - t_wr >= SETTLE, "R7 settle hold", t_off - t_wr, SETTLE);
                end
            end else begin
                chk(!ch_bypass[1], "R8 bypass cleared", int'(ch_bypass[1]), 0);
                chk(ch_ext_sel[1] == e0, "R8 select untouched", int'(ch_ext_sel[1]), int'(e0));
                if (expf != f0 && b0) chk(t_off >= 0 && t_wr > t_off, "R8 clear before write", t_wr, t_off + 1);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 190000);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        bit ok;
        int iv, t0, t1, t2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(ch_bypass == 2'b10, "R1 reset bypass", int'(ch_bypass), 2);
        chk(ch_ext_sel == 2'b01, "R1 reset select", int'(ch_ext_sel), 1);
        chk(fld(0) == 4 && fld(1) == 4, "R1 reset fields", fld(1), 4);
        chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);

        // R5 on the plain channel, bypassed from reset
        for (int i = 0; i < 20; i++) begin
            chk(ch_tick[1] == xtal_tick, "R5 reset passthrough", int'(ch_tick[1]), int'(xtal_tick));
            @(negedge clk);
        end

        // R2 reset divisor on the PLL channel
        measure(0, iv);
        chk(iv == 4, "R2 reset period", iv, 4);

        // R2/R3 exhaustive sweep of the plain channel
        for (int n = 1; n <= 256; n++) begin
            do_req(1, n, ok);
            measure(1, iv);
            chk(iv == n, "R2 plain sweep period", iv, n);
        end
        // R3 saturation above the field range
        begin
            int unsigned extra [5] = '{257, 5, 1000, 6, 65535};
            for (int k = 0; k < 5; k++) begin
                do_req(1, extra[k], ok);
                measure(1, iv);
                chk(iv == period_of((extra[k] >= 256) ? 0 : int'(extra[k])), "R3 saturated period",
                    iv, period_of((extra[k] >= 256) ? 0 : int'(extra[k])));
            end
        end

        // R6/R7/R2 on the PLL channel
        for (int n = 1; n <= 12; n++) begin
            do_req(0, n, ok);
            measure(0, iv);
            chk(iv == n, "R2 pll sweep period", iv, n);
        end
        do_req(0, 256, ok);
        measure(0, iv);
        chk(iv == 256, "R3 pll divide-by-256", iv, 256);
        do_req(0, 300, ok);
        measure(0, iv);
        chk(iv == 256, "R3 pll saturation", iv, 256);

        // R9 mid-period change, plain channel
        do_req(1, 200, ok);
        next_tick(1, t0);
        do_req(1, 3, ok);
        next_tick(1, t1);
        next_tick(1, t2);
        chk(t1 - t0 == 200, "R9 plain old period completes", t1 - t0, 200);
        chk(t2 - t1 == 3, "R9 plain new period", t2 - t1, 3);

        // R9 mid-period change, PLL channel
        do_req(0, 40, ok);
        next_tick(0, t0);
        do_req(0, 5, ok);
        next_tick(0, t1);
        next_tick(0, t2);
        chk(t1 - t0 == 40, "R9 pll old period completes", t1 - t0, 40);
        chk(t2 - t1 == 5, "R9 pll new period", t2 - t1, 5);

        // R4 zero requests on both styles
        do_req(1, 0, ok);
        measure(1, iv);
        chk(iv == 3, "R4 plain period unchanged", iv, 3);
        do_req(0, 0, ok);
        measure(0, iv);
        chk(iv == 5, "R4 pll period unchanged", iv, 5);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule